// File: doc/BRIEF.md
# Programmable YCbCr-to-RGB Color Converter

This block converts the pixel stream of a display sprite plane from YCbCr to RGB at one pixel per clock. Each pixel carries three 10-bit components: an unsigned luma and two chroma values already in signed two's complement form. Every component gets its own programmable offset and signed clamp. The three results feed a programmable 3x3 fixed-point matrix. Each of the three matrix outputs then gets its own offset and clamp before it leaves the block.

A per-pixel format flag marks RGB pixels. These skip the whole datapath but take the same number of cycles as converted pixels, so the order of the stream is kept. Pixels move in and out on valid/ready handshakes through a fixed three-stage pipeline.

Software writes the coefficients, offsets and limits into 32-bit shadow registers, each holding two 16-bit fields. A frame-start strobe copies all shadow registers into the working set in one step. After reset the working set holds a full-range conversion, so the block converts correctly without any programming.

Top module: `ycc_rgb_conv`

## Requirements
- R1: After reset the working set holds these defaults:
  - Matrix rows R = (5743·Cr + 4096·Y + 2048) >>> 12, G = (-2925·Cr + 4096·Y - 1410·Cb + 2048) >>> 12, B = (4096·Y + 7258·Cb + 2048) >>> 12.
  - All offsets are 0.
  - Input limits are Y 0..1023 and Cb/Cr -512..512.
  - Output limits are 0..1023.
  - A YCbCr pixel with Y=512, Cb=Cr=0 therefore yields R=G=B=512.
- R2: When `in_rgb` is 1, `out_data` equals the accepted `in_data` bit for bit.
- R3: Input side of a YCbCr pixel:
  - `in_data[29:20]` is Y (unsigned), `[19:10]` is Cb and `[9:0]` is Cr (both signed two's complement).
  - Each component first gets its signed 16-bit input offset added.
  - The sum is then limited to that channel's signed minimum and maximum, with the minimum tested first.
- R4: The matrix uses 16-bit signed coefficients with 12 fraction bits. Coefficient k sits in row k/3 and column k%3, with the columns ordered Cr, Y, Cb. Each row sum is kept at full precision, has 2048 added, and is then arithmetically shifted right by 12, which floors the result.
- R5: Output side:
  - Each row result gets its signed 16-bit output offset added and is then limited to that channel's signed minimum and maximum.
  - The low 10 bits of the limited value form R at `out_data[29:20]`, G at `[19:10]` and B at `[9:0]`.
- R6: Register map:
  - Each register holds a low field in bits [15:0] and a high field in bits [31:16].
  - Addresses 0..3 hold coefficients 2a (low) and 2a+1 (high). Address 4 low holds coefficient 8.
  - Address 5+i holds the input offset of Y/Cb/Cr channel i (low) and the output offset of R/G/B channel i (high).
  - Address 8+i holds the input minimum (low) and input maximum (high) of channel i.
  - Address 11+i holds the output minimum (low) and output maximum (high) of R/G/B channel i.
  - Writes to addresses 14 and 15 change nothing.
- R7: Flow control:
  - `in_ready` equals `!out_valid || out_ready`.
  - A pixel accepted on an idle pipeline appears on `out_valid` after exactly three clock edges.
  - While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold.
  - Pixels leave in the order they were accepted.
- R8: Register writes change only the shadow copy. A `frame_start` pulse loads the working set from the shadow as it stood before that same edge, so a write that coincides with `frame_start` takes effect only at the next `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data, two 16-bit fields |
| frame_start | input | 1 | Loads the working set from the shadow registers |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_rgb | input | 1 | Pixel is RGB and bypasses the conversion |
| in_data | input | 30 | Input pixel: Y, Cb, Cr from the MSB down |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream can take the output pixel |
| out_data | output | 30 | Output pixel: R, G, B from the MSB down |

## Verification
A register write and a frame-start pulse can land on the same clock edge. The commit must then take the shadow as it stood before that write. The bench provokes this by writing a new coefficient pair in the very cycle of `frame_start`. It then converts a pixel, whose result must still follow the old matrix, pulses `frame_start` alone and converts the pixel again, now expecting the new matrix. Both results are judged against a bench model that applies the commit before the write in every cycle.

// File: rtl/ycc_conv_pkg.sv
package ycc_conv_pkg;

  localparam int FLD_W     = 16;
  localparam int NUM_REGS  = 14;
  // 28 half-register fields minus the unused upper half of register 4
  localparam int NUM_SLOTS = 27;
  localparam int GAP_FIELD = 9;

  // field number (2*address + half) held by storage slot s
  function automatic int slot_field(input int s);
    return (s < GAP_FIELD) ? s : s + 1;
  endfunction

  // reset value of storage slot s: full-range conversion
  function automatic logic [FLD_W-1:0] slot_default(input int s);
    logic [FLD_W-1:0] v;
    int ch;
    int is_hi;
    v = '0;
    if (s < 9) begin
      case (s)
        0:       v = 16'd5743;
        1:       v = 16'd4096;
        3:       v = 16'hF493;   // -2925
        4:       v = 16'd4096;
        5:       v = 16'hFA7E;   // -1410
        7:       v = 16'd4096;
        8:       v = 16'd7258;
        default: v = '0;
      endcase
    end else if (s < 15) begin
      v = '0;
    end else if (s < 21) begin
      ch    = (s - 15) / 2;
      is_hi = (s - 15) % 2;
      if (ch == 0) v = (is_hi != 0) ? 16'd1023 : 16'd0;
      else         v = (is_hi != 0) ? 16'h0200 : 16'hFE00;
    end else begin
      is_hi = (s - 21) % 2;
      v = (is_hi != 0) ? 16'd1023 : 16'd0;
    end
    return v;
  endfunction

endpackage

// File: rtl/ycc_conv_regs.sv
module ycc_conv_regs
  import ycc_conv_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [ADDR_W-1:0]                   wr_addr,
  input  logic [2*FLD_W-1:0]                  wr_data,
  input  logic                                commit,
  output logic [NUM_SLOTS-1:0][FLD_W-1:0]     act_o
);

  logic [NUM_SLOTS-1:0][FLD_W-1:0] shd_q, shd_d;
  logic [NUM_SLOTS-1:0][FLD_W-1:0] act_q, act_d;

  always_comb begin
    shd_d = shd_q;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (wr_en && (int'(wr_addr) == (slot_field(s) / 2))) begin
        shd_d[s] = ((slot_field(s) % 2) != 0) ? wr_data[2*FLD_W-1:FLD_W]
                                               : wr_data[FLD_W-1:0];
      end
    end
    act_d = commit ? shd_q : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        shd_q[s] <= slot_default(s);
        act_q[s] <= slot_default(s);
      end
    end else begin
      shd_q <= shd_d;
      act_q <= act_d;
    end
  end

  assign act_o = act_q;

  // R8: working set only moves on a commit, and then to the prior shadow
  a_r8_hold_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(act_q));
  a_r8_load_prior_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (act_q == $past(shd_q)));

endmodule

// File: rtl/ycc_conv_inchan.sv
module ycc_conv_inchan
  import ycc_conv_pkg::*;
#(
  parameter int DATA_W    = 10,
  parameter bit IS_SIGNED = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [DATA_W-1:0]       din,
  input  logic [FLD_W-1:0]        off,
  input  logic [FLD_W-1:0]        lo,
  input  logic [FLD_W-1:0]        hi,
  output logic signed [FLD_W-1:0] q
);

  localparam int SUM_W = FLD_W + 1;

  logic                    ext_bit;
  logic signed [SUM_W-1:0] din_x, sum, lo_x, hi_x;
  logic signed [FLD_W-1:0] lim, q_d, q_q;

  generate
    if (IS_SIGNED) begin : g_signed
      assign ext_bit = din[DATA_W-1];
    end else begin : g_unsigned
      assign ext_bit = 1'b0;
    end
  endgenerate

  assign din_x = {{(SUM_W-DATA_W){ext_bit}}, din};
  assign sum   = din_x + SUM_W'($signed(off));
  assign lo_x  = SUM_W'($signed(lo));
  assign hi_x  = SUM_W'($signed(hi));

  always_comb begin
    if (sum < lo_x)      lim = lo;
    else if (sum > hi_x) lim = hi;
    else                 lim = sum[FLD_W-1:0];
    q_d = en ? lim : q_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q = q_q;

  // R3: a registered component never leaves its programmed window
  a_r3_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ($signed(lo) <= $signed(hi))) |=>
      ((q_q >= $signed($past(lo))) && (q_q <= $signed($past(hi)))));

endmodule

// File: rtl/ycc_conv_row.sv
module ycc_conv_row #(
  parameter int FLD_W  = 16,
  parameter int FRAC_W = 12,
  parameter int RES_W  = 2*FLD_W + 2 - FRAC_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic signed [FLD_W-1:0] x0,
  input  logic signed [FLD_W-1:0] x1,
  input  logic signed [FLD_W-1:0] x2,
  input  logic signed [FLD_W-1:0] c0,
  input  logic signed [FLD_W-1:0] c1,
  input  logic signed [FLD_W-1:0] c2,
  output logic signed [RES_W-1:0] q
);

  localparam int PROD_W = 2*FLD_W;
  localparam int ACC_W  = PROD_W + 2;
  localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(1) << (FRAC_W-1);

  logic signed [PROD_W-1:0] p0, p1, p2;
  logic signed [ACC_W-1:0]  acc;
  logic signed [RES_W-1:0]  q_d, q_q;

  assign p0  = PROD_W'(x0) * PROD_W'(c0);
  assign p1  = PROD_W'(x1) * PROD_W'(c1);
  assign p2  = PROD_W'(x2) * PROD_W'(c2);
  assign acc = ACC_W'(p0) + ACC_W'(p1) + ACC_W'(p2) + HALF_LSB;

  always_comb q_d = en ? RES_W'(acc >>> FRAC_W) : q_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q = q_q;

endmodule

// File: rtl/ycc_conv_outchan.sv
module ycc_conv_outchan #(
  parameter int FLD_W  = 16,
  parameter int RES_W  = 22,
  parameter int DATA_W = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic signed [RES_W-1:0] x,
  input  logic [FLD_W-1:0]        off,
  input  logic [FLD_W-1:0]        lo,
  input  logic [FLD_W-1:0]        hi,
  output logic [DATA_W-1:0]       q
);

  localparam int SUM_W = RES_W + 1;

  logic signed [SUM_W-1:0] sum, lo_x, hi_x;
  logic signed [FLD_W-1:0] lim, full_d, full_q;

  assign sum  = SUM_W'(x) + SUM_W'($signed(off));
  assign lo_x = SUM_W'($signed(lo));
  assign hi_x = SUM_W'($signed(hi));

  always_comb begin
    if (sum < lo_x)      lim = lo;
    else if (sum > hi_x) lim = hi;
    else                 lim = sum[FLD_W-1:0];
    full_d = en ? lim : full_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= '0;
    else        full_q <= full_d;
  end

  assign q = full_q[DATA_W-1:0];

  // R5: the limited result stays inside the output window
  a_r5_out_window: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ($signed(lo) <= $signed(hi))) |=>
      ((full_q >= $signed($past(lo))) && (full_q <= $signed($past(hi)))));

endmodule

// File: rtl/ycc_rgb_conv.sv
module ycc_rgb_conv
  import ycc_conv_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int ADDR_W = 4,
  parameter int FRAC_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [2*FLD_W-1:0]    reg_wdata,
  input  logic                  frame_start,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic                  in_rgb,
  input  logic [3*DATA_W-1:0]   in_data,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [3*DATA_W-1:0]   out_data
);

  localparam int PIX_W  = 3*DATA_W;
  localparam int RES_W  = 2*FLD_W + 2 - FRAC_W;
  localparam int STAGES = 3;

  logic [NUM_SLOTS-1:0][FLD_W-1:0] fld;

  ycc_conv_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_we),
    .wr_addr (reg_addr),
    .wr_data (reg_wdata),
    .commit  (frame_start),
    .act_o   (fld)
  );

  // pipeline control: all stages advance together
  logic                         adv;
  logic [STAGES-1:0]            vld_q, vld_d, byp_q, byp_d;
  logic [STAGES-1:0][PIX_W-1:0] raw_q, raw_d;

  assign adv      = !vld_q[STAGES-1] || out_ready;
  assign in_ready = adv;

  always_comb begin
    vld_d = adv ? {vld_q[STAGES-2:0], in_valid} : vld_q;
    byp_d = adv ? {byp_q[STAGES-2:0], in_rgb}   : byp_q;
    raw_d = adv ? {raw_q[STAGES-2:0], in_data}  : raw_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      byp_q <= '0;
      raw_q <= '0;
    end else begin
      vld_q <= vld_d;
      byp_q <= byp_d;
      raw_q <= raw_d;
    end
  end

  // stage 1: per-component offset and window (Y, Cb, Cr)
  logic [FLD_W-1:0] comp [3];

  for (genvar i = 0; i < 3; i++) begin : g_in
    ycc_conv_inchan #(.DATA_W(DATA_W), .IS_SIGNED(i != 0)) u_in (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (adv),
      .din   (in_data[PIX_W-1-i*DATA_W -: DATA_W]),
      .off   (fld[9+2*i]),
      .lo    (fld[15+2*i]),
      .hi    (fld[16+2*i]),
      .q     (comp[i])
    );
  end

  // matrix columns are ordered Cr, Y, Cb
  logic [FLD_W-1:0] vec [3];
  assign vec[0] = comp[2];
  assign vec[1] = comp[0];
  assign vec[2] = comp[1];

  // stage 2: one dot product per output row; stage 3: offset and window
  logic [RES_W-1:0]  row_res [3];
  logic [DATA_W-1:0] rgb     [3];

  for (genvar r = 0; r < 3; r++) begin : g_row
    ycc_conv_row #(.FLD_W(FLD_W), .FRAC_W(FRAC_W), .RES_W(RES_W)) u_row (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (adv),
      .x0    (vec[0]),
      .x1    (vec[1]),
      .x2    (vec[2]),
      .c0    (fld[3*r]),
      .c1    (fld[3*r+1]),
      .c2    (fld[3*r+2]),
      .q     (row_res[r])
    );

    ycc_conv_outchan #(.FLD_W(FLD_W), .RES_W(RES_W), .DATA_W(DATA_W)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (adv),
      .x     (row_res[r]),
      .off   (fld[10+2*r]),
      .lo    (fld[21+2*r]),
      .hi    (fld[22+2*r]),
      .q     (rgb[r])
    );
  end

  assign out_valid = vld_q[STAGES-1];
  assign out_data  = byp_q[STAGES-1] ? raw_q[STAGES-1] : {rgb[0], rgb[1], rgb[2]};

  // R7: a stalled output pixel is held unchanged
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: tb/ycc_rgb_conv_tb.sv
`timescale 1ns/1ps
module ycc_rgb_conv_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic        frame_start;
  logic        in_valid;
  logic        in_ready;
  logic        in_rgb;
  logic [29:0] in_data;
  logic        out_valid;
  logic        out_ready;
  logic [29:0] out_data;

  always #4 clk = ~clk;   // 125 MHz

  ycc_rgb_conv u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .frame_start(frame_start), .in_valid(in_valid),
    .in_ready(in_ready), .in_rgb(in_rgb), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] shd_m [14];
  logic [31:0] act_m [14];

  logic [29:0] src_d [512];
  bit          src_r [512];
  string       src_t [512];
  int          n_src = 0;

  logic [29:0] exp_d [512];
  string       exp_t [512];

  task automatic chk(input bit ok, input string tag, input logic [29:0] act, input logic [29:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic longint sx(input logic [15:0] v);
    logic signed [15:0] t;
    t = v;
    return longint'(t);
  endfunction

  function automatic longint coef(input int k);
    return sx(((k % 2) != 0) ? act_m[k/2][31:16] : act_m[k/2][15:0]);
  endfunction

  // expected output from the requirements
  function automatic logic [29:0] model(input logic [29:0] d, input bit rgb);
    longint xin [3];
    longint v   [3];
    longint acc, s, lo, hi;
    logic [9:0] o [3];
    logic signed [9:0] t;
    if (rgb) return d;
    xin[0] = longint'({1'b0, d[29:20]});
    t = d[19:10]; xin[1] = longint'(t);
    t = d[9:0];   xin[2] = longint'(t);
    for (int i = 0; i < 3; i++) begin
      s  = xin[i] + sx(act_m[5+i][15:0]);
      lo = sx(act_m[8+i][15:0]);
      hi = sx(act_m[8+i][31:16]);
      if (s < lo) s = lo; else if (s > hi) s = hi;
      v[i] = s;
    end
    for (int r = 0; r < 3; r++) begin
      acc = coef(3*r)*v[2] + coef(3*r+1)*v[0] + coef(3*r+2)*v[1];
      s  = ((acc + 2048) >>> 12) + sx(act_m[5+r][31:16]);
      lo = sx(act_m[11+r][15:0]);
      hi = sx(act_m[11+r][31:16]);
      if (s < lo) s = lo; else if (s > hi) s = hi;
      o[r] = s[9:0];
    end
    return {o[0], o[1], o[2]};
  endfunction

  task automatic load_defaults();
    act_m[0] = 32'h1000_166F; act_m[1] = 32'hF493_0000; act_m[2] = 32'hFA7E_1000;
    act_m[3] = 32'h1000_0000; act_m[4] = 32'h0000_1C5A;
    act_m[5] = '0; act_m[6] = '0; act_m[7] = '0;
    act_m[8] = 32'h03FF_0000; act_m[9] = 32'h0200_FE00; act_m[10] = 32'h0200_FE00;
    act_m[11] = 32'h03FF_0000; act_m[12] = 32'h03FF_0000; act_m[13] = 32'h03FF_0000;
    for (int k = 0; k < 14; k++) shd_m[k] = act_m[k];
  endtask

  // one bus cycle: commit sees the shadow before this cycle's write
  task automatic bus_cycle(input bit we, input logic [3:0] a, input logic [31:0] d, input bit fs);
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = d; frame_start = fs;
    if (fs) for (int k = 0; k < 14; k++) act_m[k] = shd_m[k];
    if (we && (a < 4'd14)) shd_m[a] = d;
    @(negedge clk);
    reg_we = 1'b0; frame_start = 1'b0;
  endtask

  task automatic push_px(input int y, input int cb, input int cr, input bit rgb, input string tag);
    logic [9:0] a, b, c;
    a = y[9:0]; b = cb[9:0]; c = cr[9:0];
    src_d[n_src] = {a, b, c};
    src_r[n_src] = rgb;
    src_t[n_src] = tag;
    n_src++;
  endtask

  task automatic stream(input int pin, input int prdy);
    int sent = 0;
    int wr = 0;
    int rd = 0;
    int guard = 0;
    bit hold_pend = 1'b0;
    logic [29:0] hold_val = '0;
    while (((sent < n_src) || (rd != wr)) && (guard < 20000)) begin
      @(negedge clk);
      if (hold_pend) chk(out_valid && (out_data == hold_val), "R7", out_data, hold_val);
      in_valid  = (sent < n_src) && ($urandom_range(99) < pin);
      in_data   = src_d[(sent < n_src) ? sent : 0];
      in_rgb    = src_r[(sent < n_src) ? sent : 0];
      out_ready = ($urandom_range(99) < prdy);
      #1;
      chk(in_ready == (!out_valid || out_ready), "R7", {29'd0, in_ready}, {29'd0, !out_valid || out_ready});
      if (in_valid && in_ready) begin
        exp_d[wr % 512] = model(src_d[sent], src_r[sent]);
        exp_t[wr % 512] = src_t[sent];
        wr++;
        sent++;
      end
      if (out_valid && out_ready) begin
        if (rd == wr) chk(1'b0, "R7", out_data, '0);
        else begin
          chk(out_data == exp_d[rd % 512], exp_t[rd % 512], out_data, exp_d[rd % 512]);
          rd++;
        end
      end
      hold_pend = out_valid && !out_ready;
      hold_val  = out_data;
      guard++;
    end
    if (guard >= 20000) chk(1'b0, "R7", '0, '1);
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    n_src = 0;
  endtask

  function automatic logic [15:0] rnd16(input int lo, input int hi);
    int v;
    v = lo + int'($urandom_range(0, hi - lo));
    return v[15:0];
  endfunction

  task automatic randomize_regs();
    logic [31:0] w;
    for (int a = 0; a < 14; a++) begin
      if (a < 4)       w = {rnd16(-8192, 8191), rnd16(-8192, 8191)};
      else if (a == 4) w = {16'h0000, rnd16(-8192, 8191)};
      else if (a < 8)  w = {rnd16(-128, 127), rnd16(-128, 127)};
      else if (a == 8) w = {rnd16(900, 1023), rnd16(0, 100)};
      else if (a < 11) w = {rnd16(300, 512), rnd16(-512, -300)};
      else             w = {rnd16(970, 1023), rnd16(0, 50)};
      bus_cycle(1'b1, a[3:0], w, 1'b0);
    end
    bus_cycle(1'b0, 4'd0, '0, 1'b1);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [29:0] e;
    void'($urandom(32'd2024));
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; frame_start = 1'b0;
    in_valid = 1'b0; in_rgb = 1'b0; in_data = '0; out_ready = 1'b1;
    load_defaults();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk(out_valid == 1'b0, "R1", {29'd0, out_valid}, '0);
    chk(in_ready == 1'b1, "R7", {29'd0, in_ready}, 30'd1);

    // latency of one pixel on an idle pipeline, default matrix
    in_valid = 1'b1; in_rgb = 1'b0; in_data = {10'd512, 10'd0, 10'd0}; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R7", {29'd0, out_valid}, '0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R7", {29'd0, out_valid}, '0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R7", {29'd0, out_valid}, 30'd1);
    chk(out_data == {10'd512, 10'd512, 10'd512}, "R1", out_data, {10'd512, 10'd512, 10'd512});

    // default corners: output limits, rounding, bypass
    push_px(1023, -512, 511, 1'b0, "R5");
    push_px(0, 511, -512, 1'b0, "R5");
    push_px(700, 100, -50, 1'b0, "R4");
    push_px(64, 0, 0, 1'b0, "R1");
    push_px(1023, 511, 511, 1'b1, "R2");
    push_px(5, -3, 200, 1'b1, "R2");
    stream(100, 100);

    // limited-range input setup: Y offset -64, narrow windows
    bus_cycle(1'b1, 4'd5, 32'h0000_FFC0, 1'b0);
    bus_cycle(1'b1, 4'd8, {16'd940, 16'd64}, 1'b0);
    bus_cycle(1'b1, 4'd9, {16'd448, 16'hFE40}, 1'b0);
    bus_cycle(1'b1, 4'd10, {16'd448, 16'hFE40}, 1'b0);
    bus_cycle(1'b0, 4'd0, '0, 1'b1);
    push_px(10, 0, 0, 1'b0, "R3");
    push_px(1023, 511, -512, 1'b0, "R3");
    push_px(500, -100, 100, 1'b0, "R3");
    stream(100, 50);

    // R8: write in the commit cycle stays pending until the next commit
    bus_cycle(1'b1, 4'd0, {16'd4096, 16'd0}, 1'b1);
    push_px(300, 0, 200, 1'b0, "R8");
    stream(100, 100);
    bus_cycle(1'b1, 4'd4, 32'h0000_0000, 1'b0);
    push_px(300, 100, 200, 1'b0, "R8");
    stream(100, 100);
    bus_cycle(1'b0, 4'd0, '0, 1'b1);
    e = model({10'd300, 10'd0, 10'd200}, 1'b0);
    chk(e[29:20] == 10'd236, "R8", {20'd0, e[29:20]}, 30'd236);
    push_px(300, 0, 200, 1'b0, "R8");
    push_px(300, 100, 200, 1'b0, "R8");
    stream(100, 100);

    // R6: unmapped addresses leave every field untouched
    bus_cycle(1'b1, 4'd14, 32'hFFFF_FFFF, 1'b0);
    bus_cycle(1'b1, 4'd15, 32'h1234_5678, 1'b0);
    bus_cycle(1'b0, 4'd0, '0, 1'b1);
    push_px(400, 50, -60, 1'b0, "R6");
    push_px(900, -300, 300, 1'b0, "R6");
    stream(100, 100);

    // constrained random rounds with random flow control
    for (int round = 0; round < 4; round++) begin
      randomize_regs();
      for (int p = 0; p < 300; p++) begin
        if ($urandom_range(4) == 0)
          push_px(int'($urandom_range(1023)), int'($urandom_range(1023)), int'($urandom_range(1023)), 1'b1, "R2");
        else
          push_px(int'($urandom_range(1023)), int'($urandom_range(1023)), int'($urandom_range(1023)), 1'b0, "R4");
      end
      stream(70, 60);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule